// File: doc/BRIEF.md
# Pointer-Steered Serial Bit Latch

This block keeps eight single-bit entries that are filled one bit at a time from a serial data pin. A 3-bit write pointer, held inside the block, selects the entry that receives the data. While the strobe input is high, the selected entry follows the serial data. When the strobe drops, the entry keeps the value that was present at that moment. The pointer moves forward by one on each falling edge of the increment input, and it wraps from the last entry back to the first.

If the strobe drops while the pointer sits on the last entry, an active-low flag goes low. It stays low until a master clear. Because the flag is active low, the flags of several blocks can be wire-ANDed into a single buffer-full line. The eight entries are presented as a parallel word. They are driven only while the active-low enable is low; otherwise the output-enable is deasserted, which models a released bus.

Everything runs on one system clock. Strobe, increment and serial data pass through the same two-stage synchronizer, so they stay aligned, and edges are found on the synchronized values. The master clear is synchronous and takes priority over strobe and increment.

Top module: `serial_bit_latch`

## Requirements
- R1: After the asynchronous system reset, every entry reads 0, the write pointer is 0 and full_n_o is 1.
- R2: While strobe is high, the entry at the pointer follows the serial data. After strobe falls, that entry keeps the data value that was present when strobe dropped.
- R3: While strobe is low, no entry changes, however the serial data moves.
- R4: During a strobe, entries other than the selected one keep their values.
- R5: The pointer steps by one only on a falling edge of increment. A rising edge, or a steady level, leaves it unchanged.
- R6: From entry 7, the next falling edge of increment moves the pointer to entry 0.
- R7: full_n_o goes low when strobe falls while the pointer is at 7. A strobe that ends at any other pointer value leaves full_n_o high.
- R8: Once low, full_n_o stays low until clear, including after the pointer wraps and further writes take place.
- R9: A high clr_i clears all entries to 0, returns the pointer to 0 and sets full_n_o to 1. It takes priority over strobe and increment, including their edges while clear is held.
- R10: With en_n_i low, q_oe_o is 1 and q_o carries the entries, with bit i being entry i. With en_n_i high, q_oe_o is 0 and q_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_d_i | input | 1 | Serial data bit |
| stb_i | input | 1 | Load strobe, active high |
| inc_i | input | 1 | Pointer advance; acts on its falling edge |
| clr_i | input | 1 | Synchronous master clear, active high |
| en_n_i | input | 1 | Active-low output enable for the parallel word |
| q_o | output | ENTRIES (8) | Parallel entries, bit i = entry i |
| q_oe_o | output | 1 | Output-enable for q_o |
| full_n_o | output | 1 | Active-low buffer-full flag |

## Verification
The embedded assertions check several properties on every cycle: entries stay stable when no strobe is active, at most one entry changes per cycle, a clear empties the store, the pointer only holds or steps by one, the full flag is sticky, and the flag rises only on a strobe fall at the last entry. The bench scenarios cover what needs end-to-end stimulus. They show that the captured bit is the one present when the strobe drops, that only the falling edge of increment counts, that the pointer wraps, that clear overrides edges that occur while it is held, and that the enable gates the output.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int unsigned SBL_ENTRIES_DEF = 8;
  localparam int unsigned SBL_SYNC_DEF    = 2;

  // Bit positions inside the synchronized input bundle
  localparam int unsigned SBL_IDX_INC = 0;
  localparam int unsigned SBL_IDX_STB = 1;
  localparam int unsigned SBL_IDX_DAT = 2;
  localparam int unsigned SBL_BUNDLE  = 3;
endpackage

// File: rtl/sbl_sync.sv
module sbl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbl_fall_det.sv
module sbl_fall_det #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/sbl_wptr.sv
module sbl_wptr #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_fall_i,
  input  logic             stb_fall_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             full_q, full_d;
  logic             ptr_en, full_en;

  always_comb begin
    ptr_en  = clr_i | inc_fall_i;
    ptr_d   = ptr_q;
    if (clr_i)                ptr_d = '0;
    else if (ptr_q == LAST)   ptr_d = '0;
    else                      ptr_d = ptr_q + PTR_W'(1);
  end

  always_comb begin
    full_en = clr_i | (stb_fall_i & (ptr_q == LAST));
    full_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (full_en) full_q <= full_d;
  end

  assign ptr_o  = ptr_q;
  assign full_o = full_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_fall_i) |=> $stable(ptr_q)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && inc_fall_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && inc_fall_i && ptr_q == LAST) |=> (ptr_q == '0)); // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr_i) |=> full_q); // R8
  AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(stb_fall_i && ptr_q == LAST && !clr_i)); // R7
  AST_CLR_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ptr_q == '0 && !full_q)); // R9
endmodule

// File: rtl/sbl_store.sv
module sbl_store #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wr_lvl_i,
  input  logic [PTR_W-1:0]   wr_ptr_i,
  input  logic               wr_dat_i,
  output logic [ENTRIES-1:0] bits_o
);
  logic [ENTRIES-1:0] bits_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic sel, en, d;
    always_comb begin
      sel = wr_lvl_i & (wr_ptr_i == PTR_W'(i));
      en  = clr_i | sel;
      d   = clr_i ? 1'b0 : wr_dat_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bits_q[i] <= 1'b0;
      else if (en) bits_q[i] <= d;
    end
  end

  assign bits_o = bits_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lvl_i && !clr_i) |=> $stable(bits_q)); // R3
  AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ($countones(bits_q ^ $past(bits_q)) <= 1)); // R4
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bits_q == '0)); // R9
endmodule

// File: rtl/serial_bit_latch.sv
module serial_bit_latch
  import sbl_pkg::*;
#(
  parameter int unsigned ENTRIES     = SBL_ENTRIES_DEF,
  parameter int unsigned SYNC_STAGES = SBL_SYNC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_d_i,
  input  logic               stb_i,
  input  logic               inc_i,
  input  logic               clr_i,
  input  logic               en_n_i,
  output logic [ENTRIES-1:0] q_o,
  output logic               q_oe_o,
  output logic               full_n_o
);
  localparam int unsigned PTR_W = $clog2(ENTRIES);

  logic [SBL_BUNDLE-1:0] raw, synced;
  logic [1:0]            falls;
  logic [PTR_W-1:0]      ptr;
  logic                  full;
  logic [ENTRIES-1:0]    bits;

  always_comb begin
    raw              = '0;
    raw[SBL_IDX_INC] = inc_i;
    raw[SBL_IDX_STB] = stb_i;
    raw[SBL_IDX_DAT] = ser_d_i;
  end

  sbl_sync #(.WIDTH(SBL_BUNDLE), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(synced)
  );

  sbl_fall_det #(.WIDTH(2)) i_fall (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({synced[SBL_IDX_STB], synced[SBL_IDX_INC]}),
    .fall_o(falls)
  );

  sbl_wptr #(.ENTRIES(ENTRIES)) i_wptr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .inc_fall_i(falls[0]), .stb_fall_i(falls[1]),
    .ptr_o(ptr), .full_o(full)
  );

  sbl_store #(.ENTRIES(ENTRIES)) i_store (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .wr_lvl_i(synced[SBL_IDX_STB]), .wr_ptr_i(ptr),
    .wr_dat_i(synced[SBL_IDX_DAT]), .bits_o(bits)
  );

  assign q_oe_o   = ~en_n_i;
  assign q_o      = en_n_i ? '0 : bits;
  assign full_n_o = ~full;

  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> full_n_o); // R9
  AST_OUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe_o |-> (q_o == '0)); // R10
endmodule

// File: tb/test_serial_bit_latch.sv
module test_serial_bit_latch;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n, ser_d, stb, inc, clr, en_n;
  logic [N-1:0] q;
  logic         q_oe, full_n;

  int           n_cmp = 0;
  int           n_bad = 0;
  logic [N-1:0] m_bits;
  int           m_ptr;
  logic         m_full;

  always #4 clk = ~clk;

  serial_bit_latch i_serial_bit_latch (
    .clk(clk), .rst_n(rst_n), .ser_d_i(ser_d), .stb_i(stb), .inc_i(inc),
    .clr_i(clr), .en_n_i(en_n), .q_o(q), .q_oe_o(q_oe), .full_n_o(full_n)
  );

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " word"}, 32'(q), 32'(m_bits));
    chk({req, " full_n"}, 32'(full_n), 32'(!m_full));
  endtask

  // One strobe pulse writing bit d at the model pointer
  task automatic write_bit(input logic d);
    ser_d = d; stb = 1'b1;
    step(5);
    stb = 1'b0;
    step(5);
    m_bits[m_ptr] = d;
    if (m_ptr == N - 1) m_full = 1'b1;
  endtask

  task automatic advance();
    inc = 1'b1; step(4);
    inc = 1'b0; step(5);
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic t_reset();
    chk("R1 oe", 32'(q_oe), 32'd1);
    chk_state("R1");
  endtask

  task automatic t_fill();
    logic [N-1:0] pat = 8'b1011_0101;
    for (int i = 0; i < N; i++) begin
      write_bit(pat[i]);
      chk_state("R2 R4 R7 fill");
      if (i != N - 1) advance();
    end
    chk("R7 full at last", 32'(full_n), 32'd0);
  endtask

  task automatic t_follow();
    // pointer at 7 here; strobe high, data moves, entry follows
    stb = 1'b1;
    ser_d = 1'b0; step(5);
    chk("R2 follow low", 32'(q[m_ptr]), 32'd0);
    ser_d = 1'b1; step(5);
    chk("R2 follow high", 32'(q[m_ptr]), 32'd1);
    stb = 1'b0; step(5);
    ser_d = 1'b0; step(5);
    m_bits[m_ptr] = 1'b1;
    chk_state("R2 keep at fall");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 6; k++) begin
      ser_d = ~ser_d; step(3);
    end
    chk_state("R3 idle data");
  endtask

  task automatic t_wrap();
    advance(); // 7 -> 0
    write_bit(~m_bits[0]);
    chk_state("R6 R8 wrap");
    chk("R8 still full", 32'(full_n), 32'd0);
  endtask

  task automatic t_rise_only();
    inc = 1'b1; step(6);
    write_bit(~m_bits[m_ptr]);
    chk_state("R5 rise no step");
    inc = 1'b0; step(5);
    m_ptr = (m_ptr + 1) % N;
    write_bit(~m_bits[m_ptr]);
    chk_state("R5 fall steps");
  endtask

  task automatic t_clear();
    stb = 1'b1; inc = 1'b1; ser_d = 1'b1;
    step(5);
    clr = 1'b1; step(2);
    stb = 1'b0; inc = 1'b0; ser_d = 1'b0;
    step(6);
    m_bits = '0; m_ptr = 0; m_full = 1'b0;
    chk_state("R9 under clear");
    clr = 1'b0; step(2);
    chk_state("R9 after clear");
    write_bit(1'b1);
    chk_state("R9 pointer at 0");
  endtask

  task automatic t_enable();
    en_n = 1'b1; step(1);
    chk("R10 oe off", 32'(q_oe), 32'd0);
    chk("R10 word off", 32'(q), 32'd0);
    en_n = 1'b0; step(1);
    chk("R10 oe on", 32'(q_oe), 32'd1);
    chk("R10 word on", 32'(q), 32'(m_bits));
  endtask

  initial begin
    rst_n = 1'b0; ser_d = 1'b0; stb = 1'b0; inc = 1'b0; clr = 1'b0; en_n = 1'b0;
    m_bits = '0; m_ptr = 0; m_full = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_fill();
    t_follow();
    t_idle();
    t_enable();
    t_wrap();
    t_rise_only();
    t_clear();
    t_enable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule